// File: doc/BRIEF.md
# PLL Digital Lock Detector with Hysteresis

This block watches the two pulse trains that meet at a phase-frequency detector. One is the reference pulse and the other is the divided-down oscillator pulse. It drives an active-high lock flag. A fast measurement clock times every comparison: it counts the cycles between the rising edge that arrives first and the rising edge that arrives second, whichever of the two leads. That count is the phase error of the comparison. The count of the most recent comparison is presented on an output, together with a one-cycle strobe.

The lock flag is set only after a run of consecutive comparisons whose error stays below a narrow limit. Once set, it is cleared only by an error at or above a wider limit. The gap between the two limits gives hysteresis: a loop that jitters a little around the narrow limit does not make the flag toggle. Both limits and the run length are parameters in measurement-clock cycles. With a 200 MHz measurement clock, limits of 3 and 5 cycles correspond to 15 ns and 25 ns.

Both pulse inputs are synchronised into the measurement-clock domain with the same number of stages, so the measured difference is kept. The reset is asserted asynchronously and released synchronously.

Top module: `pll_lock_detector`

## Requirements
- R1: During and after reset, and before any comparison completes, lock_o is 0, err_o is 0 and err_vld_o is 0.
- R2: Each completed comparison reports on err_o the number of measurement-clock cycles between the first and the second rising edge. The value is the same whether the reference or the feedback edge leads.
- R3: Reference and feedback edges that arrive in the same measurement-clock cycle complete a comparison with an error of 0.
- R4: While unlocked, lock_o rises after GOOD_RUN consecutive comparisons (default 5) whose error is below LOCK_CYC (default 3). After only GOOD_RUN-1 such comparisons, lock_o is still 0.
- R5: While unlocked, a comparison with an error of LOCK_CYC or more sets the consecutive-good count back to zero, so a full new run of GOOD_RUN good comparisons is needed.
- R6: While locked, comparisons with an error below UNLOCK_CYC (default 5) keep lock_o at 1. This includes errors from LOCK_CYC up to UNLOCK_CYC-1.
- R7: While locked, a comparison with an error of UNLOCK_CYC or more clears lock_o, and acquiring lock again then needs a fresh run of GOOD_RUN good comparisons.
- R8: A second rising edge on the leading input before the other input has produced an edge completes the open comparison with the saturated error 2^ERR_W-1 (255 by default) and opens a new comparison at that edge.
- R9: The error count saturates at 2^ERR_W-1 when the second edge comes later than that many cycles.
- R10: err_o changes only in a cycle in which err_vld_o is 1, and it holds its value between comparisons.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_meas | input | 1 | Fast measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse_i | input | 1 | Reference pulse into the phase detector |
| fb_pulse_i | input | 1 | Divided-oscillator feedback pulse |
| lock_o | output | 1 | Lock flag, active high |
| err_o | output | ERR_W | Phase error of the latest comparison, in measurement-clock cycles |
| err_vld_o | output | 1 | One-cycle strobe marking a new err_o value |

## Verification
Some rules are checked by assertions on every cycle:
- a coincident pair of edges gives a zero result;
- a repeated leading edge gives the saturated result;
- err_o moves only with its strobe;
- the lock flag rises only at the end of a complete good run;
- the flag holds between comparisons;
- a large error drops the flag;
- an unlocked bad comparison clears the run counter.

Other behaviour is shown only by the bench's scenarios. These are the exact error values for either edge order, saturation over a long window, the exact number of good comparisons needed to acquire lock, and the hysteresis band in which lock survives errors of 3 and 4 cycles. The bench covers them with directed sequences and with seeded random edge offsets that are compared against a reference model.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  typedef enum logic [1:0] {
    M_IDLE      = 2'd0,
    M_REF_FIRST = 2'd1,
    M_FB_FIRST  = 2'd2
  } meas_state_t;

endpackage

// File: rtl/lockdet_edge.sv
module lockdet_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic [STAGES-1:0] sync_d;

  // shift chain toward the MSB
  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = pulse_i;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], pulse_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/lockdet_meter.sv
module lockdet_meter
  import lockdet_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise_i,
  input  logic             fb_rise_i,
  output logic [ERR_W-1:0] err_o,
  output logic             vld_o
);

  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};
  localparam logic [ERR_W-1:0] ERR_ONE = {{(ERR_W-1){1'b0}}, 1'b1};

  meas_state_t      st_q, st_d;
  logic [ERR_W-1:0] cnt_q, cnt_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic             vld_q, vld_d;
  logic             lead_rise, lag_rise;
  logic [ERR_W-1:0] cnt_inc;

  assign cnt_inc   = (cnt_q == ERR_MAX) ? cnt_q : cnt_q + ERR_ONE;
  assign lead_rise = (st_q == M_REF_FIRST) ? ref_rise_i : fb_rise_i;
  assign lag_rise  = (st_q == M_REF_FIRST) ? fb_rise_i  : ref_rise_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    err_d = err_q;
    vld_d = 1'b0;
    if (st_q == M_IDLE) begin
      if (ref_rise_i && fb_rise_i) begin
        vld_d = 1'b1;
        err_d = '0;
      end else if (ref_rise_i) begin
        st_d  = M_REF_FIRST;
        cnt_d = ERR_ONE;
      end else if (fb_rise_i) begin
        st_d  = M_FB_FIRST;
        cnt_d = ERR_ONE;
      end
    end else begin
      if (lag_rise) begin
        vld_d = 1'b1;
        err_d = cnt_q;
        if (lead_rise) begin
          cnt_d = ERR_ONE;
        end else begin
          st_d  = M_IDLE;
          cnt_d = '0;
        end
      end else if (lead_rise) begin
        // slipped cycle: leading input fired twice
        vld_d = 1'b1;
        err_d = ERR_MAX;
        cnt_d = ERR_ONE;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= M_IDLE;
      cnt_q <= '0;
      err_q <= '0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      vld_q <= vld_d;
      if (vld_d) begin
        err_q <= err_d;
      end
    end
  end

  assign err_o = err_q;
  assign vld_o = vld_q;

  AST_COINCIDENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_IDLE && ref_rise_i && fb_rise_i) |=> (vld_q && err_q == '0)); // R3

  AST_SLIP_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_REF_FIRST && ref_rise_i && !fb_rise_i) |=> (vld_q && err_q == ERR_MAX)); // R8

  AST_ERR_ONLY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != $past(err_q)) |-> vld_q); // R10

endmodule

// File: rtl/lockdet_judge.sv
module lockdet_judge #(
  parameter int ERR_W      = 8,
  parameter int LOCK_CYC   = 3,
  parameter int UNLOCK_CYC = 5,
  parameter int GOOD_RUN   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] err_i,
  input  logic             vld_i,
  output logic             lock_o
);

  localparam int RUN_W = (GOOD_RUN < 2) ? 1 : $clog2(GOOD_RUN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(GOOD_RUN - 1);
  localparam logic [ERR_W-1:0] LOCK_LIM = ERR_W'(LOCK_CYC);
  localparam logic [ERR_W-1:0] UNLK_LIM = ERR_W'(UNLOCK_CYC);

  logic             lock_q, lock_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             upd_en;

  assign upd_en = vld_i;

  always_comb begin
    lock_d = lock_q;
    run_d  = run_q;
    if (lock_q) begin
      if (err_i >= UNLK_LIM) begin
        lock_d = 1'b0;
        run_d  = '0;
      end
    end else if (err_i < LOCK_LIM) begin
      if (run_q == RUN_LAST) begin
        lock_d = 1'b1;
        run_d  = '0;
      end else begin
        run_d = run_q + RUN_W'(1);
      end
    end else begin
      run_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      run_q  <= '0;
    end else if (upd_en) begin
      lock_q <= lock_d;
      run_q  <= run_d;
    end
  end

  assign lock_o = lock_q;

  AST_LOCK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> ($past(vld_i) && $past(run_q) == RUN_LAST && $past(err_i) < LOCK_LIM)); // R4

  AST_BAD_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && vld_i && err_i >= LOCK_LIM) |=> (run_q == '0 && !lock_q)); // R5

  AST_LOCK_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !vld_i) |=> lock_q); // R6

  AST_LARGE_ERR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && vld_i && err_i >= UNLK_LIM) |=> !lock_q); // R7

endmodule

// File: rtl/pll_lock_detector.sv
module pll_lock_detector #(
  parameter int ERR_W       = 8,
  parameter int LOCK_CYC    = 3,
  parameter int UNLOCK_CYC  = 5,
  parameter int GOOD_RUN    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_meas,
  input  logic             rst_n,
  input  logic             ref_pulse_i,
  input  logic             fb_pulse_i,
  output logic             lock_o,
  output logic [ERR_W-1:0] err_o,
  output logic             err_vld_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       ref_rise, fb_rise;
  logic [ERR_W-1:0] meas_err;
  logic       meas_vld;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk_meas or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  lockdet_edge #(.STAGES(SYNC_STAGES)) u_ref_edge (
    .clk     (clk_meas),
    .rst_n   (rst_n_int),
    .pulse_i (ref_pulse_i),
    .rise_o  (ref_rise)
  );

  lockdet_edge #(.STAGES(SYNC_STAGES)) u_fb_edge (
    .clk     (clk_meas),
    .rst_n   (rst_n_int),
    .pulse_i (fb_pulse_i),
    .rise_o  (fb_rise)
  );

  lockdet_meter #(.ERR_W(ERR_W)) u_meter (
    .clk        (clk_meas),
    .rst_n      (rst_n_int),
    .ref_rise_i (ref_rise),
    .fb_rise_i  (fb_rise),
    .err_o      (meas_err),
    .vld_o      (meas_vld)
  );

  lockdet_judge #(
    .ERR_W      (ERR_W),
    .LOCK_CYC   (LOCK_CYC),
    .UNLOCK_CYC (UNLOCK_CYC),
    .GOOD_RUN   (GOOD_RUN)
  ) u_judge (
    .clk    (clk_meas),
    .rst_n  (rst_n_int),
    .err_i  (meas_err),
    .vld_i  (meas_vld),
    .lock_o (lock_o)
  );

  assign err_o     = meas_err;
  assign err_vld_o = meas_vld;

  AST_RESET_QUIET: assert property (@(posedge clk_meas)
    (!rst_n_int) |-> (!lock_o && !err_vld_o && err_o == '0)); // R1

endmodule

// File: tb/pll_lock_detector_tb.sv
module pll_lock_detector_tb;

  localparam int ERR_W = 8;
  localparam int ERR_MAX = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_p = 1'b0;
  logic fb_p = 1'b0;
  logic lock;
  logic [ERR_W-1:0] err;
  logic err_vld;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  bit m_lock = 1'b0;
  int m_run = 0;
  int m_err = 0;

  always #4 clk = ~clk;

  pll_lock_detector u_dut (
    .clk_meas    (clk),
    .rst_n       (rst_n),
    .ref_pulse_i (ref_p),
    .fb_pulse_i  (fb_p),
    .lock_o      (lock),
    .err_o       (err),
    .err_vld_o   (err_vld)
  );

  function automatic int abs_sat(int d);
    int a;
    a = (d < 0) ? -d : d;
    return (a > ERR_MAX) ? ERR_MAX : a;
  endfunction

  task automatic model(int e);
    m_err = e;
    if (m_lock) begin
      if (e >= 5) begin m_lock = 1'b0; m_run = 0; end
    end else if (e < 3) begin
      m_run++;
      if (m_run == 5) begin m_lock = 1'b1; m_run = 0; end
    end else begin
      m_run = 0;
    end
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    check(int'(err) == m_err, {req, " err"}, int'(err), m_err);
    check(lock == m_lock, {req, " lock"}, int'(lock), int'(m_lock));
  endtask

  task automatic pulse_ref(); ref_p = 1'b1; @(negedge clk); ref_p = 1'b0; endtask
  task automatic pulse_fb();  fb_p  = 1'b1; @(negedge clk); fb_p  = 1'b0; endtask

  // d > 0: reference leads by d cycles; d < 0: feedback leads
  task automatic compare(int d);
    int a;
    a = (d < 0) ? -d : d;
    @(negedge clk);
    if (d == 0) begin
      ref_p = 1'b1; fb_p = 1'b1;
      @(negedge clk);
      ref_p = 1'b0; fb_p = 1'b0;
    end else begin
      if (d > 0) pulse_ref(); else pulse_fb();
      repeat (a - 1) @(negedge clk);
      if (d > 0) pulse_fb(); else pulse_ref();
    end
    repeat (8) @(negedge clk);
    model(abs_sat(d));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check(lock == 1'b0 && err == '0 && err_vld == 1'b0, "R1 in reset", int'(lock), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(lock == 1'b0 && err == '0 && err_vld == 1'b0, "R1 after reset", int'(err), 0);

    // R2 both orders
    compare(7);  check_state("R2 ref leads");
    compare(-6); check_state("R2 fb leads");
    compare(0);  check_state("R3 coincident");

    // R5 run broken at the fourth comparison
    compare(1); compare(-2); compare(0);
    compare(3); check_state("R5 bad resets run");
    compare(2); compare(1); compare(-1); compare(0);
    check_state("R4 four goods no lock");
    compare(2); check_state("R4 fifth good locks");

    // R6 hysteresis band
    compare(3);  check_state("R6 err 3 keeps lock");
    compare(-4); check_state("R6 err 4 keeps lock");
    compare(5);  check_state("R7 err 5 releases");
    compare(1); compare(1); compare(1); compare(1);
    check_state("R7 relock needs full run");
    compare(1); check_state("R7 relock");

    // R8 slip: two reference edges, then feedback
    @(negedge clk);
    pulse_ref();
    repeat (9) @(negedge clk);
    pulse_ref();
    @(negedge clk);
    pulse_fb();
    repeat (8) @(negedge clk);
    model(ERR_MAX); model(2);
    check_state("R8 slip");

    // R9 saturation
    compare(300); check_state("R9 saturate");
    compare(-270); check_state("R9 saturate fb lead");

    // R10 hold without activity
    repeat (30) @(negedge clk);
    check(int'(err) == m_err && err_vld == 1'b0, "R10 hold", int'(err), m_err);

    // random offsets
    for (int i = 0; i < 80; i++) begin
      int d;
      if (($urandom % 10) < 7) d = int'($urandom % 5) - 2;
      else d = int'($urandom % 17) - 8;
      compare(d);
      check_state("R2 R4 R6 R7 random");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule